// File: doc/BRIEF.md
# Pipelined Jacobi Row Update Unit

This block computes one point-form Jacobi update per clock. A caller presents a complete matrix row, the current solution estimate, the row's right-hand-side entry, the row's diagonal coefficient and the index of the row. The block multiplies every coefficient by the matching solution entry in parallel. It drops the product that sits on the diagonal position and reduces the rest through a registered binary adder tree. It then subtracts that sum from the right-hand side and divides by the diagonal to form the row's next solution entry.

All values are signed fixed point with `DW` total bits and `FRAC` fraction bits. A new row may enter on every cycle. Results leave in entry order after a fixed latency, each with its own valid flag. A zero diagonal is reported on an error output, and results that do not fit in `DW` bits are clamped.

Top module: `jac_row_eval`

## Requirements
- R1: For an accepted row with index i, `x_o` equals trunc((b·2^FRAC − Σ_{j≠i} a_j·x_j) / d) taken as raw signed integers, with truncation toward zero. Entry j of `a_row_i` and `x_vec_i` occupies bits [j·DW +: DW].
- R2: The coefficient at position `row_idx_i` of `a_row_i` has no effect on the result. The divisor comes only from `diag_i`.
- R3: Rows can be accepted on every consecutive cycle. Each result appears exactly LAT = 1 + log2(N) + 1 + (2·DW + log2(N) + 1) + 1 cycles after its row is accepted (40 for the defaults), and results keep entry order.
- R4: `valid_o` is high only for cycles that carry the result of an accepted row. Idle input cycles produce no output.
- R5: When `diag_i` is zero, the result carries `div_err_o` = 1. `x_o` is then 0x7FFF-style positive full scale if the numerator is ≥ 0, and negative full scale (0x8000 pattern) otherwise.
- R6: A nonzero-diagonal quotient above 2^(DW−1)−1 gives positive full scale, and one below −2^(DW−1) gives negative full scale. Neither case raises `div_err_o`.
- R7: While reset is low, and before any result, `valid_o`, `div_err_o` and `x_o` are all zero.
- R8: `div_err_o` is never high in a cycle where `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Row present this cycle |
| row_idx_i | input | $clog2(N) | Position of the diagonal within the row |
| a_row_i | input | N·DW | Row coefficients, entry j at [j·DW +: DW] |
| x_vec_i | input | N·DW | Current solution vector, same packing |
| b_i | input | DW | Right-hand-side entry of the row |
| diag_i | input | DW | Diagonal coefficient of the row |
| valid_o | output | 1 | Result present this cycle |
| x_o | output | DW | Next solution entry for the row |
| div_err_o | output | 1 | Diagonal was zero for this result |

## Verification
A masking fault at the multiplier array shows on the first result, because the bench places a large, distinct coefficient on the diagonal slot. A broken tree node or subtract stage shows as a wrong `x_o` exactly LAT cycles after the affected row. A divider stage that mis-steps corrupts the quotient of every row that passes through it. A lost or duplicated valid bit shows either as a latency mismatch or as an output with no row behind it, within one LAT window. A wrong sign or zero-diagonal flag shows as the wrong full-scale value, or as a wrong error bit, on the very row concerned.

// File: rtl/jac_pkg.sv
package jac_pkg;
  typedef struct packed {
    logic neg_q;  // quotient negative
    logic neg_r;  // numerator negative
    logic zero;   // divisor was zero
  } div_flags_t;
endpackage

// File: rtl/jac_mul_row.sv
module jac_mul_row #(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int IW = 2,
  parameter int PW = 2 * DW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [IW-1:0]   row_idx_i,
  input  logic [N*DW-1:0] a_row_i,
  input  logic [N*DW-1:0] x_vec_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   diag_i,
  output logic            valid_o,
  output logic [N*PW-1:0] prod_o,
  output logic [DW-1:0]   b_o,
  output logic [DW-1:0]   diag_o
);
  for (genvar j = 0; j < N; j++) begin : g_mul
    logic signed [DW-1:0] a_s, x_s;
    logic signed [PW-1:0] p_s;
    assign a_s = a_row_i[j*DW +: DW];
    assign x_s = x_vec_i[j*DW +: DW];
    assign p_s = a_s * x_s;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        prod_o[j*PW +: PW] <= '0;
      else if (row_idx_i == IW'(j))       prod_o[j*PW +: PW] <= '0;
      else                                prod_o[j*PW +: PW] <= p_s;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      b_o     <= '0;
      diag_o  <= '0;
    end else begin
      valid_o <= valid_i;
      b_o     <= b_i;
      diag_o  <= diag_i;
    end
  end

  p_mask_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> prod_o[$past(row_idx_i)*PW +: PW] == '0)
    else $error("diagonal product not masked");
endmodule

// File: rtl/jac_add_tree.sv
module jac_add_tree #(
  parameter int N     = 4,
  parameter int LOG2N = 2,
  parameter int PW    = 32,
  parameter int ACC   = PW + LOG2N,
  parameter int SBW   = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [N*PW-1:0]       prod_i,
  input  logic [SBW-1:0]        sb_i,
  output logic                  valid_o,
  output logic signed [ACC-1:0] sum_o,
  output logic [SBW-1:0]        sb_o
);
  // heap layout: level l starts at 2N - (2N >> l)
  logic signed [ACC-1:0] node [2*N-1];
  logic                  v_l  [LOG2N+1];
  logic [SBW-1:0]        sb_l [LOG2N+1];

  for (genvar j = 0; j < N; j++) begin : g_leaf
    assign node[j] = {{(ACC-PW){prod_i[j*PW+PW-1]}}, prod_i[j*PW +: PW]};
  end
  assign v_l[0]  = valid_i;
  assign sb_l[0] = sb_i;

  for (genvar l = 0; l < LOG2N; l++) begin : g_lvl
    localparam int IN_OFF  = 2*N - ((2*N) >> l);
    localparam int OUT_OFF = 2*N - ((2*N) >> (l+1));
    localparam int CNT     = N >> (l+1);
    for (genvar m = 0; m < CNT; m++) begin : g_node
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) node[OUT_OFF+m] <= '0;
        else         node[OUT_OFF+m] <= node[IN_OFF+2*m] + node[IN_OFF+2*m+1];
      end
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_l[l+1]  <= 1'b0;
        sb_l[l+1] <= '0;
      end else begin
        v_l[l+1]  <= v_l[l];
        sb_l[l+1] <= sb_l[l];
      end
    end
  end

  assign valid_o = v_l[LOG2N];
  assign sb_o    = sb_l[LOG2N];
  assign sum_o   = node[2*N-2];
endmodule

// File: rtl/jac_div_pipe.sv
module jac_div_pipe
  import jac_pkg::*;
#(
  parameter int NW = 35,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [NW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  input  div_flags_t    flags_i,
  output logic          valid_o,
  output logic [NW-1:0] quo_o,
  output div_flags_t    flags_o
);
  // restoring division, one quotient bit per registered stage
  logic          v_q   [NW];
  logic [DW-1:0] rem_q [NW];
  logic [NW-1:0] num_q [NW];
  logic [NW-1:0] quo_q [NW];
  logic [DW-1:0] den_q [NW];
  div_flags_t    fl_q  [NW];

  for (genvar k = 0; k < NW; k++) begin : g_stg
    logic          v_s;
    logic [DW-1:0] rem_s, den_s;
    logic [NW-1:0] num_s, quo_s;
    div_flags_t    fl_s;
    logic [DW:0]   trial, diff;
    logic          ge;

    if (k == 0) begin : g_first
      assign v_s   = valid_i;
      assign rem_s = '0;
      assign num_s = num_i;
      assign quo_s = '0;
      assign den_s = den_i;
      assign fl_s  = flags_i;
    end else begin : g_next
      assign v_s   = v_q[k-1];
      assign rem_s = rem_q[k-1];
      assign num_s = num_q[k-1];
      assign quo_s = quo_q[k-1];
      assign den_s = den_q[k-1];
      assign fl_s  = fl_q[k-1];
    end

    assign trial = {rem_s, num_s[NW-1]};
    assign diff  = trial - {1'b0, den_s};
    assign ge    = trial >= {1'b0, den_s};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q[k]   <= 1'b0;
        rem_q[k] <= '0;
        num_q[k] <= '0;
        quo_q[k] <= '0;
        den_q[k] <= '0;
        fl_q[k]  <= '0;
      end else begin
        v_q[k]   <= v_s;
        rem_q[k] <= ge ? diff[DW-1:0] : trial[DW-1:0];
        num_q[k] <= num_s << 1;
        quo_q[k] <= {quo_s[NW-2:0], ge};
        den_q[k] <= den_s;
        fl_q[k]  <= fl_s;
      end
    end
  end

  assign valid_o = v_q[NW-1];
  assign quo_o   = quo_q[NW-1];
  assign flags_o = fl_q[NW-1];

  p_rem_lt_den_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !flags_o.zero) |-> rem_q[NW-1] < den_q[NW-1])
    else $error("final remainder not below divisor");
endmodule

// File: rtl/jac_row_eval.sv
module jac_row_eval
  import jac_pkg::*;
#(
  parameter int N    = 4,
  parameter int DW   = 16,
  parameter int FRAC = 8,
  localparam int IW  = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [IW-1:0]   row_idx_i,
  input  logic [N*DW-1:0] a_row_i,
  input  logic [N*DW-1:0] x_vec_i,
  input  logic [DW-1:0]   b_i,
  input  logic [DW-1:0]   diag_i,
  output logic            valid_o,
  output logic [DW-1:0]   x_o,
  output logic            div_err_o
);
  localparam int LOG2N = $clog2(N);
  localparam int PW    = 2 * DW;
  localparam int ACC   = PW + LOG2N;
  localparam int NW    = ACC + 1;
  localparam int LAT   = 1 + LOG2N + 1 + NW + 1;
  localparam logic [NW-1:0] POS_LIM = NW'((64'd1 << (DW-1)) - 64'd1);
  localparam logic [NW-1:0] NEG_LIM = NW'(64'd1 << (DW-1));
  localparam logic [DW-1:0] POS_FS  = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FS  = {1'b1, {(DW-1){1'b0}}};

  // multiply stage
  logic            m_valid;
  logic [N*PW-1:0] m_prod;
  logic [DW-1:0]   m_b, m_diag;

  jac_mul_row #(.N(N), .DW(DW), .IW(IW), .PW(PW)) u_mul (
    .clk_i, .rst_ni, .valid_i, .row_idx_i, .a_row_i, .x_vec_i, .b_i, .diag_i,
    .valid_o(m_valid), .prod_o(m_prod), .b_o(m_b), .diag_o(m_diag)
  );

  // reduction tree, b and diag ride as sideband
  logic                  t_valid;
  logic signed [ACC-1:0] t_sum;
  logic [2*DW-1:0]       t_sb;

  jac_add_tree #(.N(N), .LOG2N(LOG2N), .PW(PW), .ACC(ACC), .SBW(2*DW)) u_tree (
    .clk_i, .rst_ni, .valid_i(m_valid), .prod_i(m_prod), .sb_i({m_b, m_diag}),
    .valid_o(t_valid), .sum_o(t_sum), .sb_o(t_sb)
  );

  // subtract stage
  logic signed [NW-1:0] b_sh, r_d;
  logic                 s_valid;
  logic signed [NW-1:0] s_r;
  logic [DW-1:0]        s_diag;

  assign b_sh = {{(NW-DW){t_sb[2*DW-1]}}, t_sb[2*DW-1:DW]} <<< FRAC;
  assign r_d  = b_sh - {t_sum[ACC-1], t_sum};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_valid <= 1'b0;
      s_r     <= '0;
      s_diag  <= '0;
    end else begin
      s_valid <= t_valid;
      s_r     <= r_d;
      s_diag  <= t_sb[DW-1:0];
    end
  end

  // sign-magnitude conversion into the divider
  logic [NW-1:0] num_mag;
  logic [DW-1:0] den_mag;
  div_flags_t    s_fl;

  assign num_mag    = s_r[NW-1] ? NW'(-s_r) : NW'(s_r);
  assign den_mag    = s_diag[DW-1] ? DW'(-s_diag) : s_diag;
  assign s_fl.neg_r = s_r[NW-1];
  assign s_fl.neg_q = s_r[NW-1] ^ s_diag[DW-1];
  assign s_fl.zero  = (s_diag == '0);

  logic          d_valid;
  logic [NW-1:0] d_quo;
  div_flags_t    d_fl;

  jac_div_pipe #(.NW(NW), .DW(DW)) u_div (
    .clk_i, .rst_ni, .valid_i(s_valid), .num_i(num_mag), .den_i(den_mag),
    .flags_i(s_fl), .valid_o(d_valid), .quo_o(d_quo), .flags_o(d_fl)
  );

  // sign restore and clamp
  logic [DW-1:0] x_d;
  always_comb begin
    if (d_fl.zero)             x_d = d_fl.neg_r ? NEG_FS : POS_FS;
    else if (!d_fl.neg_q)      x_d = (d_quo > POS_LIM) ? POS_FS : d_quo[DW-1:0];
    else                       x_d = (d_quo > NEG_LIM) ? NEG_FS : DW'(-d_quo[DW-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      x_o       <= '0;
      div_err_o <= 1'b0;
    end else begin
      valid_o   <= d_valid;
      x_o       <= d_valid ? x_d : '0;
      div_err_o <= d_valid & d_fl.zero;
    end
  end

  // in-flight row count for pipeline checks
  localparam int OW = $clog2(LAT + 2) + 1;
  logic [OW-1:0] occ;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ <= '0;
    else         occ <= occ + OW'(valid_i) - OW'(valid_o);
  end

  p_err_with_valid_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> valid_o) else $error("error flag without valid");
  p_sat_on_err_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_err_o |-> (x_o == POS_FS || x_o == NEG_FS)) else $error("zero divisor not clamped");
  p_occ_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= OW'(LAT)) else $error("too many rows in flight");
  p_no_orphan_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> occ != '0) else $error("result with no row behind it");
endmodule

// File: tb/tb_jac_row_eval.sv
module tb_jac_row_eval;
  localparam int CLK_P = 10;
  localparam int N = 4, DW = 16, FRAC = 8, LOG2N = 2;
  localparam int LAT = 1 + LOG2N + 1 + (2*DW + LOG2N + 1) + 1;

  logic clk = 0, rst_ni = 0;
  logic valid_i = 0;
  logic [1:0] row_idx_i = '0;
  logic [N*DW-1:0] a_row_i = '0, x_vec_i = '0;
  logic [DW-1:0] b_i = '0, diag_i = '0;
  logic valid_o, div_err_o;
  logic [DW-1:0] x_o;

  jac_row_eval #(.N(N), .DW(DW), .FRAC(FRAC)) dut (
    .clk_i(clk), .rst_ni, .valid_i, .row_idx_i, .a_row_i, .x_vec_i,
    .b_i, .diag_i, .valid_o, .x_o, .div_err_o
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0, n_out = 0, err_no_valid = 0;
  int exp_x_q[$], exp_t_q[$];
  bit exp_e_q[$];
  string exp_r_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input int a[N], input int x[N], input int b, input int d,
                                input int idx, output int q, output bit e);
    longint s = 0, r, q64;
    for (int j = 0; j < N; j++) if (j != idx) s += longint'(a[j]) * longint'(x[j]);
    r = longint'(b) * (64'sd1 << FRAC) - s;
    e = (d == 0);
    if (e) q = (r < 0) ? -32768 : 32767;
    else begin
      q64 = r / longint'(d);
      if (q64 > 32767) q = 32767;
      else if (q64 < -32768) q = -32768;
      else q = int'(q64);
    end
  endfunction

  // output monitor
  always @(negedge clk) begin
    if (rst_ni) begin
      if (div_err_o && !valid_o) err_no_valid++;
      if (valid_o) begin
        n_out++;
        if (exp_x_q.size() == 0) chk(0, "R4 spurious output", int'($signed(x_o)), 0);
        else begin
          int ex, et; bit ee; string rq;
          ex = exp_x_q.pop_front(); ee = exp_e_q.pop_front();
          et = exp_t_q.pop_front(); rq = exp_r_q.pop_front();
          chk(int'($signed(x_o)) == ex, {rq, " x_o"}, int'($signed(x_o)), ex);
          chk(div_err_o == ee, {rq, " div_err_o"}, int'(div_err_o), int'(ee));
          chk(cyc - et == LAT, "R3 latency", cyc - et, LAT);
        end
      end
    end
  end

  task automatic send_row(input int a[N], input int x[N], input int b, input int d,
                          input int idx, input string req);
    int q; bit e;
    @(negedge clk);
    for (int j = 0; j < N; j++) begin
      a_row_i[j*DW +: DW] = DW'(a[j]);
      x_vec_i[j*DW +: DW] = DW'(x[j]);
    end
    b_i = DW'(b); diag_i = DW'(d); row_idx_i = 2'(idx); valid_i = 1;
    model(a, x, b, d, idx, q, e);
    exp_x_q.push_back(q); exp_e_q.push_back(e);
    exp_t_q.push_back(cyc); exp_r_q.push_back(req);
  endtask

  task automatic go_idle();
    @(negedge clk); valid_i = 0;
  endtask

  task automatic drain(input string req);
    int w = 0;
    go_idle();
    while (exp_x_q.size() != 0 && w < 4*LAT) begin @(negedge clk); w++; end
    chk(exp_x_q.size() == 0, {req, " all results returned"}, exp_x_q.size(), 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(valid_o == 0, "R7 valid_o in reset", int'(valid_o), 0);
    chk(div_err_o == 0, "R7 div_err_o in reset", int'(div_err_o), 0);
    chk(x_o == 0, "R7 x_o in reset", int'(x_o), 0);
    rst_ni = 1;
    @(negedge clk);
    chk(valid_o == 0 && x_o == 0, "R7 idle after reset", int'(x_o), 0);
  endtask

  task automatic t_basic();
    send_row('{999, 256, -128, 64}, '{100, 256, 512, -256}, 1000, 512, 0, "R1");
    send_row('{300, -700, 45, 640}, '{-33, 1200, 77, 9}, -2500, -640, 3, "R1");
    send_row('{17, 512, -3, 8}, '{400, -5, 256, 1}, 37, 512, 1, "R1");
    drain("R1");
  endtask

  task automatic t_diag_ignore();
    int n0 = n_out;
    send_row('{100, 200, 5, -300}, '{256, 128, 30000, -64}, 500, 384, 2, "R2");
    send_row('{100, 200, 32767, -300}, '{256, 128, 30000, -64}, 500, 384, 2, "R2");
    send_row('{100, 200, -32768, -300}, '{256, 128, 30000, -64}, 500, 384, 2, "R2");
    drain("R2");
    chk(n_out - n0 == 3, "R2 result count", n_out - n0, 3);
  endtask

  task automatic t_stream();
    int n0 = n_out;
    for (int k = 0; k < 12; k++) begin
      int a[N], x[N];
      for (int j = 0; j < N; j++) begin
        a[j] = (k * 37 + j * 91) % 700 - 350;
        x[j] = (k * 53 - j * 29) % 900 - 400;
      end
      send_row(a, x, k * 211 - 1200, (k % 2 == 0) ? 256 + k * 9 : -(300 + k * 7), k % N, "R3");
    end
    drain("R3");
    chk(n_out - n0 == 12, "R3 back-to-back count", n_out - n0, 12);
  endtask

  task automatic t_idle();
    int n0 = n_out;
    go_idle();
    repeat (2 * LAT) @(negedge clk);
    chk(n_out == n0, "R4 no output while idle", n_out - n0, 0);
  endtask

  task automatic t_zero_diag();
    send_row('{1, 2, 3, 4}, '{10, 10, 10, 10}, 300, 0, 0, "R5");
    send_row('{1, 2, 3, 4}, '{10, 10, 10, 10}, -300, 0, 1, "R5");
    send_row('{0, 0, 0, 0}, '{0, 0, 0, 0}, 0, 0, 2, "R5");
    drain("R5");
  endtask

  task automatic t_overflow();
    send_row('{0, 0, 0, 0}, '{0, 0, 0, 0}, 20000, 1, 0, "R6");
    send_row('{0, 0, 0, 0}, '{0, 0, 0, 0}, -20000, 1, 0, "R6");
    send_row('{0, 32767, 32767, 32767}, '{0, 32767, 32767, 32767}, 0, -1, 0, "R6");
    send_row('{0, 0, 0, 0}, '{0, 0, 0, 0}, -128, 1, 3, "R6");
    drain("R6");
  endtask

  task automatic finish_run();
    chk(err_no_valid == 0, "R8 div_err_o only with valid_o", err_no_valid, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_basic();
        t_diag_ignore();
        t_stream();
        t_idle();
        t_zero_diag();
        t_overflow();
        t_idle();
      end
      begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    finish_run();
  end
endmodule